// File: doc/BRIEF.md
# JTAG Debug Access Register Bank

This block holds the three data registers that sit behind a JTAG debug port and let an external debugger serve memory accesses that the processor raises while it is halted in debug. The processor presents a pending access (address, size, direction and, for stores, the store value) and keeps it up until the block returns a finish strobe. The debugger selects one of the three registers with a 3-bit instruction code, then runs it through capture, shift and update. It reads the access address and the store data, supplies fetch or load data, and closes the access by writing 0 to the pending bit of the control register.

The TAP state machine, the instruction register and the processor are outside the block. The TAP side runs on TCK. The processor side runs on its own clock, and every crossing between the two clocks goes through a synchronizer. A processor reset sets a sticky reset-seen flag in the control register. While that flag is set, control writes are refused unless the same write clears it, so a debugger cannot act on an access that a reset has made stale.

Top module: `dbg_access_bank`

## Requirements
- R1: The shift register is 32 bits wide and shifts LSB first from `tdi` to `tdo`. Instruction codes: 1 selects the address register, 2 the data register, 3 the control register. Any other code captures 0, and its update changes no register.
- R2: While an access is pending, capturing the address register returns address bits [31:2] with a 2-bit lane code in bits [1:0]. For address low bits a[1:0], the lane code is a[1:0] for byte (size 00), {a[1],0} for halfword (01), 00 for word (10) and {0,a[0]} for triple-byte (11).
- R3: While a write access is pending, capturing the data register returns the processor's store value.
- R4: An update of the data register, followed by a finish of a pending read, makes `acc_done` pulse high for exactly one processor clock. `acc_rdata` then holds the written value. A finish produces exactly one pulse.
- R5: The data register does not act as memory. Its capture returns 0 whenever no write access is pending, including just after a value has been written into it.
- R6: A control update takes effect only if the reset-seen flag (bit 31) is already 0 or the written bit 31 is 0. Otherwise the update changes no control bit and does not finish an access.
- R7: Reset-seen reads 1 after TCK reset and after every processor reset. Writing 0 to it clears it once the synchronized processor reset has gone low. Writing 1 to it has no effect.
- R8: The read/write bits debug-interrupt request (bit 12) and system-reset request (bit 16) return their written value at the very next capture, even when capture follows update directly.
- R9: Control status bits: pending at bit 18, write direction at bit 20 (1 = write), size at bits [25:24], low-power at bit 9, debug-mode at bit 3. Direction and size read 0 when no access is pending. All other bits read 0.
- R10: Writing 0 to the pending bit during a pending access finishes it, and pending reads 0 at the next capture. Writing 1 leaves the access pending and produces no finish.
- R11: The debug-interrupt and system-reset request bits reach `dbg_int_req` and `sys_rst_req` through a synchronizer in the processor clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| tap_ir | input | 3 | Instruction code selecting the data register |
| tap_capture | input | 1 | Capture-DR state strobe |
| tap_shift | input | 1 | Shift-DR state strobe |
| tap_update | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift register bit 0) |
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Synchronous active-high processor reset |
| acc_req | input | 1 | Processor access pending, held until `acc_done` |
| acc_addr | input | 32 | Byte address of the pending access |
| acc_size | input | 2 | Access size code (see R2) |
| acc_wr | input | 1 | 1 for store, 0 for fetch/load |
| acc_wdata | input | 32 | Store value |
| cpu_dbg_mode | input | 1 | Processor is in debug mode |
| cpu_lowpower | input | 1 | Processor is in a low-power state |
| acc_rdata | output | 32 | Fetch/load data supplied by the debugger |
| acc_done | output | 1 | One-cycle finish strobe, processor domain |
| dbg_int_req | output | 1 | Debug interrupt request to the processor |
| sys_rst_req | output | 1 | Processor/peripheral reset request |

## Verification
On every TCK cycle, the assertions check that serial data enters at bit 31, that a refused control write leaves the request bits and the finish toggle alone, that a synchronized processor reset always sets reset-seen, and that an accepted finish write flips the toggle and masks pending. On the processor clock they check that the finish strobe never lasts two cycles. The lane encoding, the values returned by capture, the loaded read data, the direction and size fields, and the delayed arrival of the request bits at the processor pins need complete access scenarios with known stimulus, so only the directed bench can show them.

// File: rtl/dbg_access_pkg.sv
package dbg_access_pkg;

    localparam int DR_W = 32;
    localparam int IR_W = 3;

    typedef enum logic [IR_W-1:0] {
        IR_ADDR = 3'd1,
        IR_DATA = 3'd2,
        IR_CTRL = 3'd3
    } ir_code_e;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_TRIPLE = 2'b11
    } acc_size_e;

    // control word bit positions
    localparam int B_RSTSEEN = 31;
    localparam int B_SIZE    = 24;
    localparam int B_DIR     = 20;
    localparam int B_PEND    = 18;
    localparam int B_SYSRST  = 16;
    localparam int B_DINT    = 12;
    localparam int B_LOWPWR  = 9;
    localparam int B_DBGM    = 3;

    typedef struct packed {
        logic      rst_seen;
        acc_size_e size;
        logic      dir_wr;
        logic      pend;
        logic      sys_rst;
        logic      dint;
        logic      lowpwr;
        logic      dbgm;
    } ctrl_view_t;

    function automatic logic [1:0] lane_code(acc_size_e sz, logic [1:0] a);
        logic [1:0] r;
        case (sz)
            SZ_BYTE:   r = a;
            SZ_HALF:   r = {a[1], 1'b0};
            SZ_WORD:   r = 2'b00;
            default:   r = {1'b0, a[0]};
        endcase
        return r;
    endfunction

    function automatic logic [DR_W-1:0] pack_ctrl(ctrl_view_t v);
        logic [DR_W-1:0] w;
        w = '0;
        w[B_RSTSEEN]       = v.rst_seen;
        w[B_SIZE +: 2]     = v.size;
        w[B_DIR]           = v.dir_wr;
        w[B_PEND]          = v.pend;
        w[B_SYSRST]        = v.sys_rst;
        w[B_DINT]          = v.dint;
        w[B_LOWPWR]        = v.lowpwr;
        w[B_DBGM]          = v.dbgm;
        return w;
    endfunction

endpackage

// File: rtl/dbg_bit_sync.sv
module dbg_bit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dbg_shift_path.sv
module dbg_shift_path #(
    parameter int W = 32
) (
    input  logic         tck,
    input  logic         rst,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] sr_q,
    output logic         tdo
);
    always_ff @(posedge tck) begin
        if (rst)          sr_q <= '0;
        else if (capture) sr_q <= cap_val;
        else if (shift)   sr_q <= {tdi, sr_q[W-1:1]};
    end

    assign tdo = sr_q[0];
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_access_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            cpu_rst_seen,
    input  logic            wr_en,
    input  logic            wr_rstseen,
    input  logic            wr_pend,
    input  logic            wr_sysrst,
    input  logic            wr_dint,
    input  logic            req_s,
    input  logic            acc_wr,
    input  acc_size_e       acc_size,
    input  logic            dbgm_s,
    input  logic            lowpwr_s,
    output logic [DR_W-1:0] ctrl_word,
    output logic            rst_seen,
    output logic            dint,
    output logic            sys_rst,
    output logic            served,
    output logic            pend_view,
    output logic            fin_tgl
);
    logic       gate_open;
    ctrl_view_t view;

    assign gate_open = !rst_seen || !wr_rstseen;
    assign pend_view = req_s && !served;

    always_ff @(posedge tck) begin
        if (rst) begin
            rst_seen <= 1'b1;
            dint     <= 1'b0;
            sys_rst  <= 1'b0;
            served   <= 1'b0;
            fin_tgl  <= 1'b0;
        end else begin
            if (cpu_rst_seen)
                rst_seen <= 1'b1;
            else if (wr_en && !wr_rstseen)
                rst_seen <= 1'b0;

            if (!req_s)
                served <= 1'b0;

            if (wr_en && gate_open) begin
                dint    <= wr_dint;
                sys_rst <= wr_sysrst;
                if (pend_view && !wr_pend) begin
                    served  <= 1'b1;
                    fin_tgl <= ~fin_tgl;
                end
            end
        end
    end

    always_comb begin
        view.rst_seen = rst_seen;
        view.size     = pend_view ? acc_size : SZ_BYTE;
        view.dir_wr   = pend_view && acc_wr;
        view.pend     = pend_view;
        view.sys_rst  = sys_rst;
        view.dint     = dint;
        view.lowpwr   = lowpwr_s;
        view.dbgm     = dbgm_s;
        ctrl_word     = pack_ctrl(view);
    end
endmodule

// File: rtl/dbg_finish_xfer.sv
module dbg_finish_xfer #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         cpu_clk,
    input  logic         cpu_rst,
    input  logic         fin_tgl,
    input  logic [W-1:0] data_hold,
    output logic         acc_done,
    output logic [W-1:0] acc_rdata
);
    // synchronizer chain runs through reset so a stale toggle never pulses
    logic stg [STAGES];
    logic prev;
    logic edge_seen;

    always_ff @(posedge cpu_clk) begin
        stg[0] <= fin_tgl;
        for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        prev <= stg[STAGES-1];
    end

    assign edge_seen = stg[STAGES-1] ^ prev;

    always_ff @(posedge cpu_clk) begin
        if (cpu_rst) begin
            acc_done  <= 1'b0;
            acc_rdata <= '0;
        end else begin
            acc_done <= edge_seen;
            if (edge_seen) acc_rdata <= data_hold;
        end
    end
endmodule

// File: rtl/dbg_access_bank.sv
module dbg_access_bank
    import dbg_access_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            tck,
    input  logic            tck_rst,
    input  logic [IR_W-1:0] tap_ir,
    input  logic            tap_capture,
    input  logic            tap_shift,
    input  logic            tap_update,
    input  logic            tdi,
    output logic            tdo,
    input  logic            cpu_clk,
    input  logic            cpu_rst,
    input  logic            acc_req,
    input  logic [DR_W-1:0] acc_addr,
    input  logic [1:0]      acc_size,
    input  logic            acc_wr,
    input  logic [DR_W-1:0] acc_wdata,
    input  logic            cpu_dbg_mode,
    input  logic            cpu_lowpower,
    output logic [DR_W-1:0] acc_rdata,
    output logic            acc_done,
    output logic            dbg_int_req,
    output logic            sys_rst_req
);
    localparam int CPU2TCK_W = 4;
    localparam int TCK2CPU_W = 2;

    logic [CPU2TCK_W-1:0] cpu_bits_s;
    logic                 rst_seen_s, req_s, dbgm_s, lowpwr_s;
    logic [DR_W-1:0]      shift_q, cap_val, ctrl_word, data_hold;
    logic                 ctrl_wr, data_wr;
    logic                 rst_seen, dint, sys_rst, served, pend_view, fin_tgl;
    acc_size_e            size_e;

    assign size_e = acc_size_e'(acc_size);

    dbg_bit_sync #(.W(CPU2TCK_W), .STAGES(SYNC_STAGES)) i_sync_in (
        .clk (tck),
        .rst (tck_rst),
        .d   ({cpu_rst, acc_req, cpu_dbg_mode, cpu_lowpower}),
        .q   (cpu_bits_s)
    );
    assign {rst_seen_s, req_s, dbgm_s, lowpwr_s} = cpu_bits_s;

    assign ctrl_wr = tap_update && (tap_ir == IR_CTRL);
    assign data_wr = tap_update && (tap_ir == IR_DATA);

    always_comb begin
        case (tap_ir)
            IR_ADDR: cap_val = pend_view ?
                        {acc_addr[DR_W-1:2], lane_code(size_e, acc_addr[1:0])} : '0;
            IR_DATA: cap_val = (pend_view && acc_wr) ? acc_wdata : '0;
            IR_CTRL: cap_val = ctrl_word;
            default: cap_val = '0;
        endcase
    end

    dbg_shift_path #(.W(DR_W)) i_shift (
        .tck     (tck),
        .rst     (tck_rst),
        .capture (tap_capture),
        .shift   (tap_shift),
        .tdi     (tdi),
        .cap_val (cap_val),
        .sr_q    (shift_q),
        .tdo     (tdo)
    );

    always_ff @(posedge tck) begin
        if (tck_rst)      data_hold <= '0;
        else if (data_wr) data_hold <= shift_q;
    end

    dbg_ctrl_reg i_ctrl (
        .tck          (tck),
        .rst          (tck_rst),
        .cpu_rst_seen (rst_seen_s),
        .wr_en        (ctrl_wr),
        .wr_rstseen   (shift_q[B_RSTSEEN]),
        .wr_pend      (shift_q[B_PEND]),
        .wr_sysrst    (shift_q[B_SYSRST]),
        .wr_dint      (shift_q[B_DINT]),
        .req_s        (req_s),
        .acc_wr       (acc_wr),
        .acc_size     (size_e),
        .dbgm_s       (dbgm_s),
        .lowpwr_s     (lowpwr_s),
        .ctrl_word    (ctrl_word),
        .rst_seen     (rst_seen),
        .dint         (dint),
        .sys_rst      (sys_rst),
        .served       (served),
        .pend_view    (pend_view),
        .fin_tgl      (fin_tgl)
    );

    dbg_finish_xfer #(.W(DR_W), .STAGES(SYNC_STAGES)) i_finish (
        .cpu_clk   (cpu_clk),
        .cpu_rst   (cpu_rst),
        .fin_tgl   (fin_tgl),
        .data_hold (data_hold),
        .acc_done  (acc_done),
        .acc_rdata (acc_rdata)
    );

    dbg_bit_sync #(.W(TCK2CPU_W), .STAGES(SYNC_STAGES)) i_sync_out (
        .clk (cpu_clk),
        .rst (cpu_rst),
        .d   ({dint, sys_rst}),
        .q   ({dbg_int_req, sys_rst_req})
    );
endmodule

// File: rtl/dbg_access_checker.sv
module dbg_access_checker (
    input logic tck,
    input logic tck_rst,
    input logic cpu_clk,
    input logic cpu_rst,
    input logic tap_shift,
    input logic tap_capture,
    input logic tdi,
    input logic sr_msb,
    input logic sr_pend,
    input logic ctrl_wr,
    input logic rst_seen,
    input logic rst_seen_s,
    input logic dint,
    input logic sys_rst,
    input logic pend_view,
    input logic served,
    input logic fin_tgl,
    input logic acc_done
);
    // R1: serial input lands in the top bit on every shift
    assert_shift_in_R1: assert property (@(posedge tck) disable iff (tck_rst)
        (tap_shift && !tap_capture) |=> (sr_msb == $past(tdi)));

    // R6: a refused control write leaves request bits and finish toggle alone
    assert_ctrl_locked_R6: assert property (@(posedge tck) disable iff (tck_rst)
        (ctrl_wr && rst_seen && sr_msb) |=>
            ($stable(dint) && $stable(sys_rst) && $stable(fin_tgl)));

    // R7: synchronized processor reset always sets the sticky flag
    assert_rst_sets_flag_R7: assert property (@(posedge tck) disable iff (tck_rst)
        rst_seen_s |=> rst_seen);

    // R10: accepted finish flips the toggle and masks pending
    assert_finish_flip_R10: assert property (@(posedge tck) disable iff (tck_rst)
        (ctrl_wr && (!rst_seen || !sr_msb) && pend_view && !sr_pend) |=>
            ((fin_tgl != $past(fin_tgl)) && served));

    // R4: finish strobe is a single processor cycle
    assert_done_single_R4: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        acc_done |=> !acc_done);
endmodule

bind dbg_access_bank dbg_access_checker i_chk (
    .tck         (tck),
    .tck_rst     (tck_rst),
    .cpu_clk     (cpu_clk),
    .cpu_rst     (cpu_rst),
    .tap_shift   (tap_shift),
    .tap_capture (tap_capture),
    .tdi         (tdi),
    .sr_msb      (shift_q[31]),
    .sr_pend     (shift_q[18]),
    .ctrl_wr     (ctrl_wr),
    .rst_seen    (rst_seen),
    .rst_seen_s  (rst_seen_s),
    .dint        (dint),
    .sys_rst     (sys_rst),
    .pend_view   (pend_view),
    .served      (served),
    .fin_tgl     (fin_tgl),
    .acc_done    (acc_done)
);

// File: tb/test_dbg_access_bank.sv
`timescale 1ns/1ps
module test_dbg_access_bank;
    logic        tck = 1'b0, cpu_clk = 1'b0;
    logic        tck_rst = 1'b1, cpu_rst = 1'b1;
    logic [2:0]  tap_ir = 3'd0;
    logic        tap_capture = 1'b0, tap_shift = 1'b0, tap_update = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        acc_req = 1'b0, acc_wr = 1'b0;
    logic [31:0] acc_addr = '0, acc_wdata = '0;
    logic [1:0]  acc_size = 2'b00;
    logic        cpu_dbg_mode = 1'b0, cpu_lowpower = 1'b0;
    logic [31:0] acc_rdata;
    logic        acc_done, dbg_int_req, sys_rst_req;

    int checks = 0, fails = 0, done_cnt = 0;

    always #2.5 tck = ~tck;      // 200 MHz
    always #6   cpu_clk = ~cpu_clk;

    dbg_access_bank i_dbg_access_bank (
        .tck(tck), .tck_rst(tck_rst), .tap_ir(tap_ir), .tap_capture(tap_capture),
        .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi), .tdo(tdo),
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .cpu_dbg_mode(cpu_dbg_mode), .cpu_lowpower(cpu_lowpower),
        .acc_rdata(acc_rdata), .acc_done(acc_done),
        .dbg_int_req(dbg_int_req), .sys_rst_req(sys_rst_req)
    );

    always @(negedge cpu_clk) if (acc_done) done_cnt++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tck_wait(int n);
        repeat (n) @(negedge tck);
    endtask

    // full capture / 32 shifts / update; returns the captured word
    task automatic scan(input logic [2:0] ir, input logic [31:0] wv, output logic [31:0] rv);
        @(negedge tck);
        tap_ir = ir; tap_capture = 1'b1;
        @(negedge tck);
        tap_capture = 1'b0; tap_shift = 1'b1;
        for (int i = 0; i < 32; i++) begin
            rv[i] = tdo;
            tdi = wv[i];
            @(negedge tck);
        end
        tap_shift = 1'b0; tap_update = 1'b1;
        @(negedge tck);
        tap_update = 1'b0;
    endtask

    function automatic logic [1:0] exp_lane(logic [1:0] sz, logic [1:0] a);
        case (sz)
            2'b00: return a;
            2'b01: return {a[1], 1'b0};
            2'b10: return 2'b00;
            default: return {1'b0, a[0]};
        endcase
    endfunction

    task automatic t_reset;
        logic [31:0] rv;
        chk("R7 tdo after reset", {31'd0, tdo}, 32'd0);
        chk("R4 acc_done after reset", {31'd0, acc_done}, 32'd0);
        chk("R11 outputs after reset", {30'd0, dbg_int_req, sys_rst_req}, 32'd0);
        scan(3'd3, 32'h8000_1000, rv);
        chk("R7 reset-seen set after reset", rv, 32'h8000_0000);
    endtask

    task automatic t_lock_and_rw;
        logic [31:0] rv;
        scan(3'd3, 32'h0001_1000, rv);
        chk("R6 write with bit31=1 refused", rv, 32'h8000_0000);
        scan(3'd3, 32'h8001_1000, rv);
        chk("R8 R/W bits visible at next capture", rv, 32'h0001_1000);
        tck_wait(12);
        chk("R11 requests reach processor pins", {30'd0, dbg_int_req, sys_rst_req}, 32'd3);
        scan(3'd3, 32'h0000_0000, rv);
        chk("R7 writing 1 to cleared flag keeps it 0", rv, 32'h0001_1000);
        tck_wait(12);
        chk("R11 requests drop at processor pins", {30'd0, dbg_int_req, sys_rst_req}, 32'd0);
    endtask

    task automatic t_other_ir;
        logic [31:0] rv;
        scan(3'd5, 32'hFFFF_FFFF, rv);
        chk("R1 unknown code captures 0", rv, 32'd0);
        scan(3'd3, 32'h0000_0000, rv);
        chk("R1 unknown code update ignored", rv, 32'd0);
    endtask

    task automatic t_status;
        logic [31:0] rv;
        @(negedge cpu_clk);
        cpu_dbg_mode = 1'b1; cpu_lowpower = 1'b1;
        tck_wait(10);
        scan(3'd3, 32'h0, rv);
        chk("R9 debug-mode and low-power bits", rv, 32'h0000_0208);
        @(negedge cpu_clk);
        cpu_dbg_mode = 1'b0; cpu_lowpower = 1'b0;
        tck_wait(10);
    endtask

    task automatic do_access(logic [31:0] addr, logic [1:0] sz, logic wr,
                             logic [31:0] wdat, logic [31:0] load);
        logic [31:0] rv, exp_ctrl;
        int base;
        @(negedge cpu_clk);
        acc_req = 1'b1; acc_addr = addr; acc_size = sz; acc_wr = wr; acc_wdata = wdat;
        tck_wait(10);
        exp_ctrl = (32'd1 << 18) | (32'(wr) << 20) | (32'(sz) << 24);
        scan(3'd3, 32'h0004_0000, rv);
        chk("R9 pending/dir/size fields", rv, exp_ctrl);
        scan(3'd1, 32'h0, rv);
        chk("R2 address with lane code", rv, {addr[31:2], exp_lane(sz, addr[1:0])});
        scan(3'd2, load, rv);
        if (wr) chk("R3 store value captured", rv, wdat);
        else    chk("R5 data capture 0 during read", rv, 32'd0);
        base = done_cnt;
        scan(3'd3, 32'h0, rv);
        chk("R10 writing 1 to pending kept it pending", rv, exp_ctrl);
        chk("R10 no finish from writing 1", done_cnt, base);
        scan(3'd3, 32'h0, rv);
        chk("R10 pending clear right after finish", rv, 32'd0);
        tck_wait(40);
        chk("R4 exactly one finish pulse", done_cnt, base + 1);
        if (!wr) chk("R4 load data returned", acc_rdata, load);
        @(negedge cpu_clk);
        acc_req = 1'b0;
        tck_wait(10);
        scan(3'd2, 32'h0, rv);
        chk("R5 written data not read back", rv, 32'd0);
    endtask

    task automatic t_cpu_reset;
        logic [31:0] rv;
        int base;
        base = done_cnt;
        @(negedge cpu_clk); cpu_rst = 1'b1;
        repeat (3) @(negedge cpu_clk);
        cpu_rst = 1'b0;
        tck_wait(15);
        scan(3'd3, 32'h8000_1000, rv);
        chk("R7 processor reset sets flag", rv, 32'h8000_0000);
        scan(3'd3, 32'h0, rv);
        chk("R6 locked after processor reset", rv, 32'h8000_0000);
        scan(3'd3, 32'h0, rv);
        chk("R7 flag cleared by writing 0", rv, 32'd0);
        chk("R4 no finish pulse from reset", done_cnt, base);
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (6) @(negedge cpu_clk);
        tck_rst = 1'b0; cpu_rst = 1'b0;
        tck_wait(10);
        t_reset();
        t_lock_and_rw();
        t_other_ir();
        t_status();
        do_access(32'h1234_5677, 2'b01, 1'b0, 32'h0, 32'hCAFE_F00D);
        do_access(32'hA000_0003, 2'b00, 1'b1, 32'h5555_AAAA, 32'h0);
        do_access(32'h8000_0006, 2'b10, 1'b0, 32'h0, 32'h0BAD_BEEF);
        do_access(32'h4000_000D, 2'b11, 1'b1, 32'h0F0F_1234, 32'h0);
        do_access(32'h4000_000E, 2'b11, 1'b0, 32'h0, 32'h7654_3210);
        t_cpu_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule